// File: doc/BRIEF.md
# Dual-Port Bank-Conflict Command Scheduler

This block sits in front of a quad-data-rate SRAM whose two data ports share one double-data-rate address bus. Port A commands leave in the rising-edge address slot of a controller cycle and port B commands in the falling-edge slot of the same cycle. Each side offers commands through a valid/ready handshake carrying a write flag and an address. The bank index is a parameterized bit field of that address.

Some devices forbid port B from using, within one cycle, the bank that port A is using in that cycle. When the `restrict_en` input is high, the scheduler compares the two banks. On a match, port A issues alone and the port B command is parked in a holding register. The block then spends exactly one stall cycle in which neither side is ready and the parked command issues alone in the falling slot. When `restrict_en` is low, no comparison is made and both slots always issue together. A counter of conflict stalls is provided for efficiency monitoring.

The controller has two named states:
- `SCH_RUN`: both sides are ready. It moves to `SCH_HOLD` on a conflict and otherwise stays in `SCH_RUN`.
- `SCH_HOLD`: the stall cycle. It always returns to `SCH_RUN` on the next edge.

Slot outputs are registered. A command accepted at a clock edge appears on the slot outputs immediately after that edge.

Top module: `qdr_pair_sched`

## Requirements
- R1: While `rst` is high, at the next edge both slot valids go low, `stall_count` goes to 0, and both `a_ready` and `b_ready` are high. Any parked port B command is discarded.
- R2: In `SCH_RUN` a port A command accepted at an edge appears after that edge on `rise_valid`/`rise_wr`/`rise_addr`. The rising slot is idle after an edge at which no port A command was accepted.
- R3: A port B command accepted in `SCH_RUN` without a conflict appears after the same edge on `fall_valid`/`fall_wr`/`fall_addr`, in the same output cycle as any port A command accepted with it.
- R4: A conflict is both sides valid in `SCH_RUN`, `restrict_en` high, and equal bank fields, where bank = `addr[BANK_LSB +: BANK_W]` (default `addr[2:0]`). After the conflict edge, port A is in the rising slot and the falling slot is idle. After the following edge, the parked port B command is in the falling slot and the rising slot is idle.
- R5: In the stall cycle `a_ready` and `b_ready` are both low. Commands offered then are not accepted and issue only after a later edge at which the block is ready.
- R6: A port B command accepted with no port A command in the same cycle issues in the falling slot whatever its bank.
- R7: No bank restriction spans cycles. A port A command may use the bank that port B used in the previous cycle without any stall.
- R8: With `restrict_en` low, commands on both sides with equal banks issue together, and `stall_count` does not change.
- R9: `stall_count` increases by exactly one for each conflict and is unchanged in every other cycle.
- R10: With `restrict_en` high, commands on different banks issue together without a stall.
- R11: The write flags of the two ports pass through independently. A write on one port and a read on the other in the same cycle issue together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| restrict_en | input | 1 | High: enforce same-cycle bank exclusion |
| a_valid | input | 1 | Port A command offered |
| a_ready | output | 1 | Port A command accepted when valid |
| a_wr | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A address |
| b_valid | input | 1 | Port B command offered |
| b_ready | output | 1 | Port B command accepted when valid |
| b_wr | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B address |
| rise_valid | output | 1 | Rising-edge slot carries a command |
| rise_wr | output | 1 | Rising-edge slot write flag |
| rise_addr | output | ADDR_W | Rising-edge slot address |
| fall_valid | output | 1 | Falling-edge slot carries a command |
| fall_wr | output | 1 | Falling-edge slot write flag |
| fall_addr | output | ADDR_W | Falling-edge slot address |
| stall_count | output | CNT_W | Number of conflict stalls since reset |

## Verification
The assertions check the following on every cycle:
- each accepted port A command reaches the rising slot after one edge;
- each non-conflicting port B command reaches the falling slot after one edge;
- a same-bank pair in restricted mode produces a rising-only slot followed by a falling-only slot;
- the stall lasts exactly one cycle with both readies low;
- the counter moves only on conflicts;
- reset clears the outputs.

Only the bench scenarios can show the following:
- which command occupies the falling slot after a stall, namely the parked one and not the one offered during the stall;
- that commands offered during the stall are issued once and later;
- that a bank reused across a cycle boundary does not stall;
- that a reset during the stall drops the parked command.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic {
        SCH_RUN  = 1'b0,
        SCH_HOLD = 1'b1
    } sched_state_e;

    typedef enum logic [1:0] {
        SLOT_RISE = 2'd0,
        SLOT_FALL = 2'd1
    } slot_id_e;

endpackage

// File: rtl/bank_clash.sv
module bank_clash #(
    parameter int BANK_W = 3
) (
    input  logic              restrict_en,
    input  logic              a_live,
    input  logic              b_live,
    input  logic [BANK_W-1:0] a_bank,
    input  logic [BANK_W-1:0] b_bank,
    output logic              clash
);
    logic same_bank;

    always_comb begin
        same_bank = (a_bank == b_bank);
        clash     = restrict_en && a_live && b_live && same_bank;
    end

endmodule

// File: rtl/slot_drive.sv
module slot_drive #(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_valid,
    input  logic              load_wr,
    input  logic [ADDR_W-1:0] load_addr,
    output logic              slot_valid,
    output logic              slot_wr,
    output logic [ADDR_W-1:0] slot_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_valid <= 1'b0;
            slot_wr    <= 1'b0;
            slot_addr  <= '0;
        end else begin
            slot_valid <= load_valid;
            slot_wr    <= load_valid ? load_wr : 1'b0;
            slot_addr  <= load_valid ? load_addr : '0;
        end
    end

endmodule

// File: rtl/stall_tally.sv
module stall_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (bump)
            count <= count + ONE;
    end

endmodule

// File: rtl/qdr_pair_sched.sv
module qdr_pair_sched
    import sched_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int BANK_W   = 3,
    parameter int BANK_LSB = 0,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restrict_en,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              rise_valid,
    output logic              rise_wr,
    output logic [ADDR_W-1:0] rise_addr,
    output logic              fall_valid,
    output logic              fall_wr,
    output logic [ADDR_W-1:0] fall_addr,
    output logic [CNT_W-1:0]  stall_count
);
    localparam int NSLOT = 2;

    sched_state_e state, nxt;

    logic              clash;
    logic              park_load;
    logic              park_wr;
    logic [ADDR_W-1:0] park_addr;
    logic              bump;

    logic              ld_valid [NSLOT];
    logic              ld_wr    [NSLOT];
    logic [ADDR_W-1:0] ld_addr  [NSLOT];
    logic              so_valid [NSLOT];
    logic              so_wr    [NSLOT];
    logic [ADDR_W-1:0] so_addr  [NSLOT];

    bank_clash #(.BANK_W(BANK_W)) u_clash (
        .restrict_en (restrict_en),
        .a_live      (a_valid && (state == SCH_RUN)),
        .b_live      (b_valid && (state == SCH_RUN)),
        .a_bank      (a_addr[BANK_LSB +: BANK_W]),
        .b_bank      (b_addr[BANK_LSB +: BANK_W]),
        .clash       (clash)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= SCH_RUN;
        else
            state <= nxt;
    end

    // next state, handshake and slot loading
    always_comb begin
        nxt       = state;
        a_ready   = 1'b0;
        b_ready   = 1'b0;
        park_load = 1'b0;
        bump      = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            ld_valid[s] = 1'b0;
            ld_wr[s]    = 1'b0;
            ld_addr[s]  = '0;
        end
        unique case (state)
            SCH_RUN: begin
                a_ready            = 1'b1;
                b_ready            = 1'b1;
                ld_valid[SLOT_RISE] = a_valid;
                ld_wr[SLOT_RISE]    = a_wr;
                ld_addr[SLOT_RISE]  = a_addr;
                if (clash) begin
                    park_load = 1'b1;
                    bump      = 1'b1;
                    nxt       = SCH_HOLD;
                end else begin
                    ld_valid[SLOT_FALL] = b_valid;
                    ld_wr[SLOT_FALL]    = b_wr;
                    ld_addr[SLOT_FALL]  = b_addr;
                end
            end
            SCH_HOLD: begin
                ld_valid[SLOT_FALL] = 1'b1;
                ld_wr[SLOT_FALL]    = park_wr;
                ld_addr[SLOT_FALL]  = park_addr;
                nxt                 = SCH_RUN;
            end
            default: nxt = SCH_RUN;
        endcase
    end

    // parked port B command
    always_ff @(posedge clk) begin
        if (rst) begin
            park_wr   <= 1'b0;
            park_addr <= '0;
        end else if (park_load) begin
            park_wr   <= b_wr;
            park_addr <= b_addr;
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        slot_drive #(.ADDR_W(ADDR_W)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .load_valid (ld_valid[g]),
            .load_wr    (ld_wr[g]),
            .load_addr  (ld_addr[g]),
            .slot_valid (so_valid[g]),
            .slot_wr    (so_wr[g]),
            .slot_addr  (so_addr[g])
        );
    end

    always_comb begin
        rise_valid = so_valid[SLOT_RISE];
        rise_wr    = so_wr[SLOT_RISE];
        rise_addr  = so_addr[SLOT_RISE];
        fall_valid = so_valid[SLOT_FALL];
        fall_wr    = so_wr[SLOT_FALL];
        fall_addr  = so_addr[SLOT_FALL];
    end

    stall_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .bump  (bump),
        .count (stall_count)
    );

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
    parameter int ADDR_W   = 21,
    parameter int BANK_W   = 3,
    parameter int BANK_LSB = 0,
    parameter int CNT_W    = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              restrict_en,
    input logic              a_valid,
    input logic              a_ready,
    input logic              a_wr,
    input logic [ADDR_W-1:0] a_addr,
    input logic              b_valid,
    input logic              b_ready,
    input logic              b_wr,
    input logic [ADDR_W-1:0] b_addr,
    input logic              rise_valid,
    input logic              rise_wr,
    input logic [ADDR_W-1:0] rise_addr,
    input logic              fall_valid,
    input logic              fall_wr,
    input logic [ADDR_W-1:0] fall_addr,
    input logic [CNT_W-1:0]  stall_count
);
    logic a_go, b_go, pair_clash;

    always_comb begin
        a_go       = a_valid && a_ready;
        b_go       = b_valid && b_ready;
        pair_clash = a_go && b_go && restrict_en &&
                     (a_addr[BANK_LSB +: BANK_W] == b_addr[BANK_LSB +: BANK_W]);
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!rise_valid && !fall_valid && stall_count == '0 && a_ready && b_ready));

    assert_a_to_rise_R2: assert property (@(posedge clk) disable iff (rst)
        a_go |=> (rise_valid && rise_addr == $past(a_addr) && rise_wr == $past(a_wr)));

    assert_b_to_fall_R3: assert property (@(posedge clk) disable iff (rst)
        (b_go && !pair_clash) |=> (fall_valid && fall_addr == $past(b_addr) && fall_wr == $past(b_wr)));

    assert_clash_split_R4: assert property (@(posedge clk) disable iff (rst)
        pair_clash |=> (rise_valid && !fall_valid && !a_ready && !b_ready));

    assert_hold_issues_b_R4: assert property (@(posedge clk) disable iff (rst)
        !a_ready |=> (fall_valid && !rise_valid));

    assert_stall_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        !a_ready |=> (a_ready && b_ready));

    assert_ready_pair_R5: assert property (@(posedge clk) disable iff (rst)
        a_ready == b_ready);

    assert_free_mode_R8: assert property (@(posedge clk) disable iff (rst)
        (!restrict_en && a_go && b_go) |=> (rise_valid && fall_valid));

    assert_count_bump_R9: assert property (@(posedge clk) disable iff (rst)
        pair_clash |=> (stall_count == $past(stall_count) + 1'b1));

    assert_count_still_R9: assert property (@(posedge clk) disable iff (rst)
        !pair_clash |=> $stable(stall_count));

endmodule

bind qdr_pair_sched sched_checker #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .restrict_en(restrict_en),
    .a_valid(a_valid), .a_ready(a_ready), .a_wr(a_wr), .a_addr(a_addr),
    .b_valid(b_valid), .b_ready(b_ready), .b_wr(b_wr), .b_addr(b_addr),
    .rise_valid(rise_valid), .rise_wr(rise_wr), .rise_addr(rise_addr),
    .fall_valid(fall_valid), .fall_wr(fall_wr), .fall_addr(fall_addr),
    .stall_count(stall_count)
);

// File: tb/qdr_pair_sched_test.sv
module qdr_pair_sched_test;
    localparam int AW = 21;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          restrict_en = 1'b1;
    logic          a_valid = 1'b0, a_wr = 1'b0, b_valid = 1'b0, b_wr = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic          a_ready, b_ready;
    logic          rise_valid, rise_wr, fall_valid, fall_wr;
    logic [AW-1:0] rise_addr, fall_addr;
    logic [CW-1:0] stall_count;

    int total = 0;
    int bad = 0;
    int exp_stalls = 0;
    bit finished = 1'b0;

    qdr_pair_sched uut (
        .clk(clk), .rst(rst), .restrict_en(restrict_en),
        .a_valid(a_valid), .a_ready(a_ready), .a_wr(a_wr), .a_addr(a_addr),
        .b_valid(b_valid), .b_ready(b_ready), .b_wr(b_wr), .b_addr(b_addr),
        .rise_valid(rise_valid), .rise_wr(rise_wr), .rise_addr(rise_addr),
        .fall_valid(fall_valid), .fall_wr(fall_wr), .fall_addr(fall_addr),
        .stall_count(stall_count)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input logic av, input logic aw, input logic [AW-1:0] aa,
                       input logic bv, input logic bw, input logic [AW-1:0] ba);
        a_valid = av; a_wr = aw; a_addr = aa;
        b_valid = bv; b_wr = bw; b_addr = ba;
    endtask

    task automatic idle;
        put(1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_reset;
        rst = 1'b1; idle(); tick(); tick();
        chk("R1 rise_valid", rise_valid, 0);
        chk("R1 fall_valid", fall_valid, 0);
        chk("R1 stall_count", stall_count, 0);
        chk("R1 ready", {a_ready, b_ready}, 2'b11);
        rst = 1'b0; exp_stalls = 0;
    endtask

    task automatic t_a_only;
        restrict_en = 1'b1;
        put(1'b1, 1'b1, 21'h01234, 1'b0, 1'b0, '0); tick();
        chk("R2 rise_valid", rise_valid, 1);
        chk("R2 rise_addr", rise_addr, 21'h01234);
        chk("R2 rise_wr", rise_wr, 1);
        chk("R2 fall idle", fall_valid, 0);
        idle(); tick();
        chk("R2 rise idle after", rise_valid, 0);
    endtask

    task automatic t_both_diff;
        restrict_en = 1'b1;
        put(1'b1, 1'b1, 21'h00201, 1'b1, 1'b0, 21'h0F002); tick();
        chk("R10 rise_addr", rise_addr, 21'h00201);
        chk("R3 fall_valid", fall_valid, 1);
        chk("R3 fall_addr", fall_addr, 21'h0F002);
        chk("R11 wr pair", {rise_wr, fall_wr}, 2'b10);
        chk("R10 no stall", stall_count, exp_stalls);
        chk("R10 still ready", a_ready, 1);
        idle(); tick();
    endtask

    task automatic t_conflict;
        restrict_en = 1'b1;
        put(1'b1, 1'b1, 21'h00105, 1'b1, 1'b0, 21'h00A3D);
        chk("R5 ready before", a_ready, 1);
        tick(); exp_stalls++;
        chk("R4 rise_valid", rise_valid, 1);
        chk("R4 rise_addr", rise_addr, 21'h00105);
        chk("R4 fall idle", fall_valid, 0);
        chk("R5 stall not ready", {a_ready, b_ready}, 2'b00);
        chk("R9 count bump", stall_count, exp_stalls);
        put(1'b1, 1'b0, 21'h00042, 1'b1, 1'b1, 21'h00013); tick();
        chk("R4 rise idle", rise_valid, 0);
        chk("R4 fall_valid", fall_valid, 1);
        chk("R4 parked addr", fall_addr, 21'h00A3D);
        chk("R4 parked wr", fall_wr, 0);
        chk("R5 ready again", a_ready, 1);
        tick();
        chk("R5 late A", rise_addr, 21'h00042);
        chk("R5 late B", fall_addr, 21'h00013);
        chk("R9 count still", stall_count, exp_stalls);
        idle(); tick();
        chk("R5 no repeat", {rise_valid, fall_valid}, 2'b00);
    endtask

    task automatic t_b_alone;
        restrict_en = 1'b1;
        put(1'b1, 1'b0, 21'h00006, 1'b0, 1'b0, '0); tick();
        put(1'b0, 1'b0, '0, 1'b1, 1'b1, 21'h00016); tick();
        chk("R6 fall_valid", fall_valid, 1);
        chk("R6 fall_addr", fall_addr, 21'h00016);
        chk("R6 rise idle", rise_valid, 0);
        chk("R6 no stall", stall_count, exp_stalls);
        idle(); tick();
    endtask

    task automatic t_cross;
        restrict_en = 1'b1;
        put(1'b1, 1'b0, 21'h00001, 1'b1, 1'b0, 21'h00005); tick();
        put(1'b1, 1'b1, 21'h00105, 1'b1, 1'b0, 21'h00002);
        chk("R7 ready", a_ready, 1);
        tick();
        chk("R7 both", {rise_valid, fall_valid}, 2'b11);
        chk("R7 rise_addr", rise_addr, 21'h00105);
        chk("R7 no stall", stall_count, exp_stalls);
        idle(); tick();
    endtask

    task automatic t_free;
        restrict_en = 1'b0;
        put(1'b1, 1'b0, 21'h00307, 1'b1, 1'b1, 21'h1FFFF); tick();
        chk("R8 both", {rise_valid, fall_valid}, 2'b11);
        chk("R8 fall_addr", fall_addr, 21'h1FFFF);
        chk("R11 wr pair", {rise_wr, fall_wr}, 2'b01);
        chk("R8 ready", a_ready, 1);
        chk("R8 no stall", stall_count, exp_stalls);
        idle(); tick();
        restrict_en = 1'b1;
    endtask

    task automatic t_reset_mid_stall;
        restrict_en = 1'b1;
        put(1'b1, 1'b0, 21'h00044, 1'b1, 1'b1, 21'h00084); tick();
        chk("R4 stall entered", a_ready, 0);
        rst = 1'b1; idle(); tick();
        chk("R1 mid-stall fall", fall_valid, 0);
        chk("R1 mid-stall count", stall_count, 0);
        chk("R1 mid-stall ready", {a_ready, b_ready}, 2'b11);
        rst = 1'b0; exp_stalls = 0; tick();
        chk("R1 parked dropped", fall_valid, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_a_only();
        t_both_diff();
        t_conflict();
        t_b_alone();
        t_cross();
        t_free();
        t_conflict();
        t_reset_mid_stall();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule